// File: doc/BRIEF.md
# PWM Fault Override Controller

This block sits on the path from an eight-channel PWM generator to the output pins. When a protection event is present, it replaces selected PWM signals with a safe idle level. A protection event can come from either of two external fault lines, or from a debug-halt indication when that source is enabled. The raw PWM signals pass through without a register. The decision to override comes from a small state machine. The two fault lines and the halt line are first brought into the clock domain by a two-flop synchronizer.

A local configuration register holds the settings. It is loaded from the `cfg_*` inputs on any clock edge where `cfg_we` is high. The settings are:
- which channels are overridden: all eight, or only channels 5..0;
- whether debug halt counts as a fault;
- the active polarity of each fault line;
- the idle level of each output;
- whether a fault is released on its own when the sources clear, or held until software clears it.

The state machine has three states:
- `ST_CLEAR`: no override.
- `ST_TRIP`: override that releases on its own.
- `ST_HELD`: override that software must clear.

Its transitions are:
- CLEAR→TRIP when a source becomes active in cycle mode.
- CLEAR→HELD when a source becomes active in latched mode.
- TRIP→CLEAR when all sources go inactive.
- TRIP→HELD when latched mode is selected while a source is still active.
- HELD→CLEAR when no source is active and either the clear strobe is high or latched mode has been turned off.

Top module: `pwm_fault_gate`

## Requirements
- R1: After reset, `fault_flag` is 0 and `pwm_out` equals `pwm_raw`. The register defaults are: both fault polarities active-low, all eight channels overridden, debug halt disabled as a source, cycle mode, and every idle level 0.
- R2: Either fault line alone, when active, causes a fault. `fault_flag` rises on the third rising clock edge after the line changes (two synchronizer flops, then the state register).
- R3: A polarity bit of 1 makes its fault line active-high. A polarity bit of 0 makes it active-low.
- R4: With `cfg_all_chan`=1 and a fault present, all eight `pwm_out` bits equal the idle levels, and none follows `pwm_raw`.
- R5: With `cfg_all_chan`=0 and a fault present, `pwm_out[5:0]` take the idle levels, while `pwm_out[7:6]` keep following `pwm_raw[7:6]`.
- R6: An overridden output bit i is driven to idle level bit i, so a 1 there gives a high output.
- R7: With halt enabled, an active-high `dbg_halt` produces the same fault and override as an external fault, with the same three-edge latency.
- R8: With halt disabled, `dbg_halt` has no effect on `fault_flag` or `pwm_out`.
- R9: In cycle mode (`cfg_latch`=0), the override releases three edges after all sources go inactive.
- R10: In latched mode (`cfg_latch`=1), the override stays set after the sources go inactive, until `clr_strobe` is high on an edge where no source is active. A strobe while a source is active is ignored.
- R11: `fault_flag` is high exactly while the override is applied, and it changes on the same edge as `pwm_out`.
- R12: The configuration changes only on edges where `cfg_we` is high. Changing the `cfg_*` inputs while `cfg_we` is low leaves the behaviour unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fault_a_in | input | 1 | External fault line A (asynchronous) |
| fault_b_in | input | 1 | External fault line B (asynchronous) |
| dbg_halt | input | 1 | Debug-halt indication, active-high (asynchronous) |
| pwm_raw | input | 8 | PWM signals from the duty-cycle logic |
| cfg_we | input | 1 | Load strobe for the configuration register |
| cfg_all_chan | input | 1 | 1: override all channels; 0: override channels 5..0 only |
| cfg_halt_en | input | 1 | 1: debug halt acts as a fault |
| cfg_pol_a | input | 1 | Line A polarity, 1 active-high |
| cfg_pol_b | input | 1 | Line B polarity, 1 active-high |
| cfg_latch | input | 1 | 1: latched mode; 0: cycle mode |
| cfg_idle | input | 8 | Idle level for each output |
| clr_strobe | input | 1 | Software clear for latched mode |
| pwm_out | output | 8 | Gated PWM outputs |
| fault_flag | output | 1 | High while the override is applied |

## Verification
The assertions take two things for granted:
- The configuration register holds steady while a latched fault is being judged.
- The synchronized fault lines move together, so the source term never briefly shows a combination that the stimulus did not intend.

The bench keeps within this in two ways. Random configuration rewrites happen only in cycle mode, where a transient cannot be latched. In latched mode, the configuration is fixed, and the fault lines are set to their inactive levels and cleared before random fault patterns begin. All inputs change at the falling edge and are then held for at least four cycles before the outputs are compared with the bench model.

// File: rtl/pwm_fault_pkg.sv
package pwm_fault_pkg;

    typedef enum logic [1:0] {
        ST_CLEAR = 2'd0,
        ST_TRIP  = 2'd1,
        ST_HELD  = 2'd2
    } fstate_e;

    typedef struct packed {
        logic all_chan;
        logic halt_en;
        logic pol_a;
        logic pol_b;
        logic latch;
    } ctl_t;

    localparam ctl_t CTL_RESET = '{all_chan: 1'b1, halt_en: 1'b0,
                                   pol_a: 1'b0, pol_b: 1'b0, latch: 1'b0};

endpackage

// File: rtl/pfo_sync.sv
module pfo_sync #(
    parameter int           WIDTH   = 3,
    parameter int           STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] chain [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain[s] <= RST_VAL;
                else        chain[s] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain[s] <= RST_VAL;
                else        chain[s] <= chain[s-1];
            end
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/pfo_cfg.sv
module pfo_cfg
    import pwm_fault_pkg::*;
#(
    parameter int N_OUT = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  ctl_t             ctl_d,
    input  logic [N_OUT-1:0] idle_d,
    output ctl_t             ctl_q,
    output logic [N_OUT-1:0] idle_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q  <= CTL_RESET;
            idle_q <= '0;
        end else if (we) begin
            ctl_q  <= ctl_d;
            idle_q <= idle_d;
        end
    end
endmodule

// File: rtl/pfo_fsm.sv
module pfo_fsm
    import pwm_fault_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    src,
    input  logic    latch,
    input  logic    clr,
    output fstate_e state,
    output logic    override
);
    fstate_e nxt;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_CLEAR: if (src) nxt = latch ? ST_HELD : ST_TRIP;
            ST_TRIP: begin
                if (!src)      nxt = ST_CLEAR;
                else if (latch) nxt = ST_HELD;
            end
            ST_HELD:  if (!src && (clr || !latch)) nxt = ST_CLEAR;
            default:  nxt = ST_CLEAR;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_CLEAR;
        else        state <= nxt;
    end

    always_comb begin
        override = (state != ST_CLEAR);
    end
endmodule

// File: rtl/pwm_fault_gate.sv
module pwm_fault_gate
    import pwm_fault_pkg::*;
#(
    parameter int N_OUT  = 8,
    parameter int N_LOW  = 6,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fault_a_in,
    input  logic             fault_b_in,
    input  logic             dbg_halt,
    input  logic [N_OUT-1:0] pwm_raw,
    input  logic             cfg_we,
    input  logic             cfg_all_chan,
    input  logic             cfg_halt_en,
    input  logic             cfg_pol_a,
    input  logic             cfg_pol_b,
    input  logic             cfg_latch,
    input  logic [N_OUT-1:0] cfg_idle,
    input  logic             clr_strobe,
    output logic [N_OUT-1:0] pwm_out,
    output logic             fault_flag
);
    localparam int NSRC = 3;

    ctl_t             ctl_d, ctl_q;
    logic [N_OUT-1:0] idle_q;
    logic [NSRC-1:0]  sync_q;
    logic             act_a, act_b, act_h, fault_src, override;
    fstate_e          fsm_state;

    assign ctl_d = '{all_chan: cfg_all_chan, halt_en: cfg_halt_en,
                     pol_a: cfg_pol_a, pol_b: cfg_pol_b, latch: cfg_latch};

    pfo_cfg #(.N_OUT(N_OUT)) u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (cfg_we),
        .ctl_d  (ctl_d),
        .idle_d (cfg_idle),
        .ctl_q  (ctl_q),
        .idle_q (idle_q)
    );

    pfo_sync #(.WIDTH(NSRC), .STAGES(STAGES), .RST_VAL(3'b011)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({dbg_halt, fault_b_in, fault_a_in}),
        .q     (sync_q)
    );

    assign act_a     = ctl_q.pol_a ? sync_q[0] : ~sync_q[0];
    assign act_b     = ctl_q.pol_b ? sync_q[1] : ~sync_q[1];
    assign act_h     = ctl_q.halt_en & sync_q[2];
    assign fault_src = act_a | act_b | act_h;

    pfo_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .src      (fault_src),
        .latch    (ctl_q.latch),
        .clr      (clr_strobe),
        .state    (fsm_state),
        .override (override)
    );

    for (genvar i = 0; i < N_OUT; i++) begin : g_out
        logic forced;
        if (i < N_LOW) begin : g_low
            assign forced = override;
        end else begin : g_high
            assign forced = override & ctl_q.all_chan;
        end
        assign pwm_out[i] = forced ? idle_q[i] : pwm_raw[i];
    end

    assign fault_flag = override;
endmodule

// File: rtl/pfo_checker.sv
module pfo_checker
    import pwm_fault_pkg::*;
#(
    parameter int N_OUT = 8,
    parameter int N_LOW = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             src,
    input  logic             act_a,
    input  logic             act_b,
    input  fstate_e          state,
    input  logic             clr,
    input  ctl_t             ctl,
    input  logic [N_OUT-1:0] idle,
    input  logic [N_OUT-1:0] pwm_raw,
    input  logic [N_OUT-1:0] pwm_out,
    input  logic             fault_flag
);
    assert_rise_needs_src_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fault_flag) |-> $past(src));

    assert_all_forced_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_flag && ctl.all_chan) |-> (pwm_out == idle));

    assert_top_pair_runs_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_flag && !ctl.all_chan) |-> (pwm_out[N_OUT-1:N_LOW] == pwm_raw[N_OUT-1:N_LOW]));

    assert_held_stays_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HELD && !clr && ctl.latch) |=> fault_flag);

    assert_held_active_src_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HELD && src) |=> fault_flag);

    assert_cycle_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_TRIP && !src && !ctl.latch) |=> !fault_flag);

    assert_halt_masked_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CLEAR && !ctl.halt_en && !act_a && !act_b) |=> !fault_flag);
endmodule

bind pwm_fault_gate pfo_checker #(.N_OUT(N_OUT), .N_LOW(N_LOW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .src        (fault_src),
    .act_a      (act_a),
    .act_b      (act_b),
    .state      (fsm_state),
    .clr        (clr_strobe),
    .ctl        (ctl_q),
    .idle       (idle_q),
    .pwm_raw    (pwm_raw),
    .pwm_out    (pwm_out),
    .fault_flag (fault_flag)
);

// File: tb/pwm_fault_gate_bench.sv
module pwm_fault_gate_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fault_a_in = 1'b1, fault_b_in = 1'b1, dbg_halt = 1'b0;
    logic [7:0] pwm_raw = 8'hA5;
    logic       cfg_we = 1'b0, cfg_all_chan = 1'b1, cfg_halt_en = 1'b0;
    logic       cfg_pol_a = 1'b0, cfg_pol_b = 1'b0, cfg_latch = 1'b0;
    logic [7:0] cfg_idle = 8'h00;
    logic       clr_strobe = 1'b0;
    logic [7:0] pwm_out;
    logic       fault_flag;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    // bench copy of the configuration
    bit       m_all = 1, m_halt = 0, m_pa = 0, m_pb = 0, m_latch = 0;
    bit [7:0] m_idle = 8'h00;
    bit       m_held = 0;

    always #10 clk = ~clk;

    pwm_fault_gate u_pwm_fault_gate (
        .clk(clk), .rst_n(rst_n), .fault_a_in(fault_a_in), .fault_b_in(fault_b_in),
        .dbg_halt(dbg_halt), .pwm_raw(pwm_raw), .cfg_we(cfg_we),
        .cfg_all_chan(cfg_all_chan), .cfg_halt_en(cfg_halt_en), .cfg_pol_a(cfg_pol_a),
        .cfg_pol_b(cfg_pol_b), .cfg_latch(cfg_latch), .cfg_idle(cfg_idle),
        .clr_strobe(clr_strobe), .pwm_out(pwm_out), .fault_flag(fault_flag)
    );

    function automatic bit src_now(bit a, bit b, bit h);
        return ((m_pa ? a : !a) || (m_pb ? b : !b) || (m_halt && h));
    endfunction

    function automatic bit [7:0] exp_out(bit [7:0] raw, bit flag);
        bit [7:0] mask = m_all ? 8'hFF : 8'h3F;
        if (!flag) return raw;
        return (raw & ~mask) | (m_idle & mask);
    endfunction

    task automatic check(string req, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_all(string req);
        check(req, {7'd0, fault_flag, pwm_out}, {7'd0, m_held, exp_out(pwm_raw, m_held)});
    endtask

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write_cfg(bit all, bit halt, bit pa, bit pb, bit lat, bit [7:0] idle);
        cfg_all_chan = all; cfg_halt_en = halt; cfg_pol_a = pa; cfg_pol_b = pb;
        cfg_latch = lat; cfg_idle = idle; cfg_we = 1'b1;
        step(1);
        cfg_we = 1'b0;
        m_all = all; m_halt = halt; m_pa = pa; m_pb = pb; m_latch = lat; m_idle = idle;
    endtask

    task automatic pulse_clr();
        clr_strobe = 1'b1;
        step(1);
        clr_strobe = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        // R1 reset state
        step(2);
        check("R1 reset flag/out", {7'd0, fault_flag, pwm_out}, {7'd0, 1'b0, 8'hA5});
        rst_n = 1'b1;
        step(4);
        check("R1 after reset", {7'd0, fault_flag, pwm_out}, {7'd0, 1'b0, 8'hA5});

        // R2 latency, R1 defaults (active-low, all channels, idle 0)
        fault_a_in = 1'b0;
        step(2);
        check("R2 no flag after two edges", {15'd0, fault_flag}, 16'd0);
        step(1);
        check("R2 flag on third edge", {15'd0, fault_flag}, 16'd1);
        check("R1 default override to 0", {8'd0, pwm_out}, 16'h0000);
        fault_a_in = 1'b1;
        step(4);
        m_held = 0;
        check_all("R9 release in cycle mode");

        fault_b_in = 1'b0;
        step(4);
        m_held = 1;
        check_all("R2 line B alone");
        fault_b_in = 1'b1;
        step(4);
        m_held = 0;
        check_all("R9 release after B");

        // R3 active-high, R5/R6 partial override with idle levels
        fault_a_in = 1'b0; fault_b_in = 1'b0;
        write_cfg(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 8'h3C);
        pwm_raw = 8'hFF;
        step(4);
        check_all("R3 active-high lines low gives no fault");
        fault_a_in = 1'b1;
        step(4);
        m_held = 1;
        check("R5 R6 top pair runs, low six idle", {7'd0, fault_flag, pwm_out}, {7'd0, 1'b1, 8'hFC});
        pwm_raw = 8'h3F;
        step(1);
        check("R5 top pair follows raw", {8'd0, pwm_out}, {8'd0, 8'h3C});

        // R8 halt ignored, R7 halt active
        fault_a_in = 1'b0; dbg_halt = 1'b1;
        step(4);
        m_held = 0;
        check_all("R8 halt ignored when disabled");
        write_cfg(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 8'h3C);
        step(4);
        m_held = 1;
        check_all("R7 halt acts as fault");
        dbg_halt = 1'b0;
        step(4);
        m_held = 0;
        check_all("R7 halt release");

        // R10 latched mode, R4 all channels, R6 idle high bits
        write_cfg(1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 8'h81);
        pwm_raw = 8'h5A;
        fault_b_in = 1'b1;
        step(4);
        m_held = 1;
        check("R4 R6 all outputs idle", {7'd0, fault_flag, pwm_out}, {7'd0, 1'b1, 8'h81});
        fault_b_in = 1'b0;
        step(4);
        check_all("R10 held after sources clear");
        fault_a_in = 1'b1;
        step(4);
        pulse_clr();
        step(1);
        check_all("R10 clear ignored while source active");
        fault_a_in = 1'b0;
        step(4);
        check_all("R10 still held without clear");
        // R12: cfg inputs change without write enable
        cfg_all_chan = 1'b0; cfg_idle = 8'h00; cfg_latch = 1'b0;
        step(3);
        check_all("R12 config unchanged without cfg_we");
        pulse_clr();
        m_held = 0;
        check_all("R10 R11 clear releases on same edge");

        // random phase A: cycle mode, configuration rewritten each step
        for (int i = 0; i < 150; i++) begin
            bit [7:0] r = 8'($urandom);
            write_cfg(r[0], r[1], r[2], r[3], 1'b0, 8'($urandom));
            fault_a_in = r[4]; fault_b_in = r[5]; dbg_halt = r[6];
            pwm_raw = 8'($urandom);
            step(4);
            m_held = src_now(fault_a_in, fault_b_in, dbg_halt);
            check_all("R2 R3 R4 R5 R7 R8 R9 random cycle mode");
        end

        // random phase B: latched mode, fixed configuration
        write_cfg(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 8'hC3);
        fault_a_in = 1'b0; fault_b_in = 1'b1; dbg_halt = 1'b0;
        step(4);
        pulse_clr();
        m_held = 0;
        step(1);
        check_all("R10 latched start clear");
        for (int i = 0; i < 150; i++) begin
            bit [7:0] r = 8'($urandom);
            bit s;
            fault_a_in = (r[1:0] == 0); fault_b_in = (r[3:2] != 0); dbg_halt = (r[5:4] == 0);
            pwm_raw = 8'($urandom);
            step(4);
            s = src_now(fault_a_in, fault_b_in, dbg_halt);
            m_held = m_held | s;
            check_all("R10 R11 random latched");
            if (r[7:6] == 0) begin
                pulse_clr();
                if (!s) m_held = 0;
                check_all("R10 random clear");
            end
        end

        finish_run();
    end
endmodule